// File: doc/BRIEF.md
# Raster Position Interrupt Timer

This block raises a maskable interrupt and a non-maskable interrupt request from the position of a video beam. The beam position comes from outside as a horizontal count in master-clock units and a vertical line count. Software writes a horizontal compare value, a vertical compare value and an enable register. When the beam reaches the programmed position, the block waits a fixed number of master clocks and then asserts its request. The wait depends on the interrupt kind, and it may carry the assertion into the next line.

The match condition is evaluated on every master clock. A match fires on the rising edge of the condition. Enabling the vertical interrupt partway through the target line therefore counts as a match at that point. The IRQ output is a level latch that stays set until it is acknowledged or until software turns both IRQ sources off. The NMI output is a flag that stays set until its own acknowledge. While a countdown is running, further matches of the same kind are dropped.

Top module: `raster_irq_timer`

## Requirements
- R1: During and after reset, `irq` and `nmi_req` are low, and all enable bits and compare values are zero.
- R2: Write `cfg_sel`=0 to set the enable register (bit 0 NMI, bit 1 vertical IRQ, bit 2 horizontal IRQ). With only bit 1 set, the condition is `beam_v` equal to the vertical compare. A rising edge of that condition, including one caused by the enable turning on mid-line, sets `irq` 10 clocks later.
- R3: Write `cfg_sel`=1 to set the horizontal compare and `cfg_sel`=2 to set the vertical compare. With only bit 2 set, `beam_h` equal to the horizontal compare on any line sets `irq` 14 clocks later. With bits 1 and 2 both set, both compares must hold, and `irq` sets 14 clocks later.
- R4: With bit 0 set, the beam reaching line `NMI_LINE`, dot `NMI_DOT` sets `nmi_req` 2 clocks later. `nmi_req` then holds until a cycle with `nmi_ack` high.
- R5: The delay counts master clocks across line ends. A vertical match at line 215, dot 1360 asserts at line 216, dot 6 when a line is 1364 clocks long.
- R6: Once set, `irq` stays high, even after the match condition goes away. It clears in the cycle after `irq_ack` is high.
- R7: A write to a configuration register takes effect from the next cycle. The cycle in which the write occurs is evaluated with the old value.
- R8: A match that occurs while that kind's countdown is running is ignored. It neither restarts nor extends the countdown.
- R9: A write to the enable register with bits 1 and 2 both clear drops `irq` in the next cycle and cancels any pending IRQ countdown.
- R10: With bits 1 and 2 both clear, `irq` never rises, whatever the beam position and compare values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Register select: 0 enable, 1 horizontal compare, 2 vertical compare |
| cfg_wdata | input | D_W | Write data |
| beam_h | input | H_W | Horizontal beam position in master clocks |
| beam_v | input | V_W | Vertical line number |
| irq_ack | input | 1 | Acknowledge, clears the IRQ latch |
| nmi_ack | input | 1 | Acknowledge, clears the NMI flag |
| irq | output | 1 | Level IRQ request |
| nmi_req | output | 1 | NMI request flag |

## Verification
The bench targets the line-end wrap and the case where the enable is written in the cycle just before the trigger point. A design that evaluated the fresh enable in the write cycle, or that dropped the carry into the next line, would assert one dot early or on the wrong line. A second match is placed inside a running countdown. A restarting counter would then produce an extra assertion five dots later, after the acknowledge. The bench also disables the IRQ sources with a countdown in flight, so a design that only cleared the latch would still assert afterwards. Randomized positions and modes confirm that the 10-clock and 14-clock delays follow the mode.

// File: rtl/raster_irq_pkg.sv
package raster_irq_pkg;

    localparam int CNT_W     = 4;
    localparam int DLY_VERT  = 10;
    localparam int DLY_HORZ  = 14;
    localparam int DLY_NMI   = 2;

    typedef enum logic [1:0] {
        SEL_ENABLE = 2'd0,
        SEL_HCMP   = 2'd1,
        SEL_VCMP   = 2'd2,
        SEL_NONE   = 2'd3
    } cfg_sel_e;

    typedef enum logic [1:0] {
        MODE_OFF,
        MODE_VERT,
        MODE_HORZ,
        MODE_BOTH
    } irq_mode_e;

    // packed: horz is bit 2, vert bit 1, nmi bit 0
    typedef struct packed {
        logic horz;
        logic vert;
        logic nmi;
    } int_enable_t;

    function automatic irq_mode_e mode_of(int_enable_t e);
        case ({e.vert, e.horz})
            2'b10:   return MODE_VERT;
            2'b01:   return MODE_HORZ;
            2'b11:   return MODE_BOTH;
            default: return MODE_OFF;
        endcase
    endfunction

    function automatic logic [CNT_W-1:0] delay_of(irq_mode_e m);
        if (m == MODE_VERT) return CNT_W'(DLY_VERT);
        return CNT_W'(DLY_HORZ);
    endfunction

endpackage

// File: rtl/raster_cfg_regs.sv
module raster_cfg_regs
    import raster_irq_pkg::*;
#(
    parameter int H_W = 11,
    parameter int V_W = 9,
    parameter int D_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [1:0]       sel,
    input  logic [D_W-1:0]   wdata,
    output int_enable_t      en,
    output logic [H_W-1:0]   hcmp,
    output logic [V_W-1:0]   vcmp,
    output logic             irq_off_wr
);

    cfg_sel_e s;
    assign s = cfg_sel_e'(sel);

    always_ff @(posedge clk) begin
        if (rst) begin
            en   <= '0;
            hcmp <= '0;
            vcmp <= '0;
        end else if (we) begin
            case (s)
                SEL_ENABLE: en   <= int_enable_t'(wdata[2:0]);
                SEL_HCMP:   hcmp <= wdata[H_W-1:0];
                SEL_VCMP:   vcmp <= wdata[V_W-1:0];
                default: ;
            endcase
        end
    end

    assign irq_off_wr = we && (s == SEL_ENABLE) && (wdata[2:1] == 2'b00);

    // R7
    cfg_write_lands_chk: assert property (@(posedge clk) disable iff (rst)
        (we && s == SEL_HCMP) |=> (hcmp == $past(wdata[H_W-1:0])));

endmodule

// File: rtl/raster_match.sv
module raster_match
    import raster_irq_pkg::*;
#(
    parameter int H_W      = 11,
    parameter int V_W      = 9,
    parameter int NMI_LINE = 225,
    parameter int NMI_DOT  = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [H_W-1:0]   beam_h,
    input  logic [V_W-1:0]   beam_v,
    input  int_enable_t      en,
    input  logic [H_W-1:0]   hcmp,
    input  logic [V_W-1:0]   vcmp,
    output logic             irq_match,
    output logic [CNT_W-1:0] irq_delay,
    output logic             nmi_match
);

    irq_mode_e mode;
    logic      v_hit, h_hit, cond, cond_q;

    assign mode  = mode_of(en);
    assign v_hit = (beam_v == vcmp);
    assign h_hit = (beam_h == hcmp);

    always_comb begin
        case (mode)
            MODE_VERT: cond = v_hit;
            MODE_HORZ: cond = h_hit;
            MODE_BOTH: cond = v_hit && h_hit;
            default:   cond = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cond_q <= 1'b0;
        else     cond_q <= cond;
    end

    assign irq_match = cond && !cond_q;
    assign irq_delay = delay_of(mode);
    assign nmi_match = en.nmi && (beam_v == V_W'(NMI_LINE))
                              && (beam_h == H_W'(NMI_DOT));

    // R10
    off_mode_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!en.vert && !en.horz) |-> !irq_match);

endmodule

// File: rtl/raster_delay.sv
module raster_delay
    import raster_irq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cancel,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             fire
);

    logic             busy;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || cancel) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (busy) begin
            if (cnt == CNT_W'(1)) busy <= 1'b0;
            cnt <= cnt - CNT_W'(1);
        end else if (load) begin
            busy <= 1'b1;
            cnt  <= load_val - CNT_W'(1);
        end
    end

    assign fire = busy && (cnt == CNT_W'(1));

    // R8
    countdown_step_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !cancel && cnt != CNT_W'(1)) |=> (busy && cnt == $past(cnt) - CNT_W'(1)));

    // R9
    cancel_idle_chk: assert property (@(posedge clk) disable iff (rst)
        cancel |=> !busy);

endmodule

// File: rtl/raster_irq_timer.sv
module raster_irq_timer
    import raster_irq_pkg::*;
#(
    parameter int H_W       = 11,
    parameter int V_W       = 9,
    parameter int D_W       = 16,
    parameter int LINE_CLKS = 1364,
    parameter int NMI_LINE  = 225,
    parameter int NMI_DOT   = 0
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           cfg_we,
    input  logic [1:0]     cfg_sel,
    input  logic [D_W-1:0] cfg_wdata,
    input  logic [H_W-1:0] beam_h,
    input  logic [V_W-1:0] beam_v,
    input  logic           irq_ack,
    input  logic           nmi_ack,
    output logic           irq,
    output logic           nmi_req
);

    localparam logic [CNT_W-1:0] NMI_LOAD = CNT_W'(DLY_NMI);

    int_enable_t      en;
    logic [H_W-1:0]   hcmp;
    logic [V_W-1:0]   vcmp;
    logic             irq_off_wr;
    logic             irq_match, nmi_match;
    logic [CNT_W-1:0] irq_delay;
    logic             irq_fire, nmi_fire;

    raster_cfg_regs #(.H_W(H_W), .V_W(V_W), .D_W(D_W)) u_regs (
        .clk(clk), .rst(rst), .we(cfg_we), .sel(cfg_sel), .wdata(cfg_wdata),
        .en(en), .hcmp(hcmp), .vcmp(vcmp), .irq_off_wr(irq_off_wr)
    );

    raster_match #(.H_W(H_W), .V_W(V_W), .NMI_LINE(NMI_LINE), .NMI_DOT(NMI_DOT)) u_match (
        .clk(clk), .rst(rst), .beam_h(beam_h), .beam_v(beam_v),
        .en(en), .hcmp(hcmp), .vcmp(vcmp),
        .irq_match(irq_match), .irq_delay(irq_delay), .nmi_match(nmi_match)
    );

    raster_delay u_irq_dly (
        .clk(clk), .rst(rst), .cancel(irq_off_wr),
        .load(irq_match), .load_val(irq_delay), .fire(irq_fire)
    );

    raster_delay u_nmi_dly (
        .clk(clk), .rst(rst), .cancel(1'b0),
        .load(nmi_match), .load_val(NMI_LOAD), .fire(nmi_fire)
    );

    always_ff @(posedge clk) begin
        if (rst || irq_off_wr) irq <= 1'b0;
        else if (irq_fire)     irq <= 1'b1;
        else if (irq_ack)      irq <= 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst)           nmi_req <= 1'b0;
        else if (nmi_fire) nmi_req <= 1'b1;
        else if (nmi_ack)  nmi_req <= 1'b0;
    end

    // R6
    irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (irq && !irq_ack && !irq_off_wr) |=> irq);

    // R2
    irq_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(irq_fire));

    // R4
    nmi_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (nmi_req && !nmi_ack) |=> nmi_req);

    // R4
    nmi_rise_src_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(nmi_req) |-> $past(nmi_fire));

    // R5
    beam_range_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(beam_h) < LINE_CLKS));

endmodule

// File: tb/raster_irq_timer_test.sv
`timescale 1ns/1ps
module raster_irq_timer_test;

    localparam int LINE  = 1364;
    localparam int LINES = 262;
    localparam int FRAME = LINE * LINES;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = 2'd0;
    logic [15:0] cfg_wdata = '0;
    logic [10:0] bh = '0;
    logic [8:0]  bv = '0;
    logic        irq_ack = 1'b0, nmi_ack = 1'b0;
    logic        irq, nmi_req;
    logic        jmp = 1'b0;
    logic [10:0] jh = '0;
    logic [8:0]  jv = '0;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    raster_irq_timer uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .beam_h(bh), .beam_v(bv), .irq_ack(irq_ack), .nmi_ack(nmi_ack),
        .irq(irq), .nmi_req(nmi_req)
    );

    always @(posedge clk) begin
        if (jmp) begin
            bh <= jh;
            bv <= jv;
        end else if (bh == 11'(LINE - 1)) begin
            bh <= '0;
            bv <= (bv == 9'(LINES - 1)) ? '0 : bv + 9'd1;
        end else begin
            bh <= bh + 11'd1;
        end
    end

    function automatic int idx(int v, int h);
        return v * LINE + h;
    endfunction

    // first match from start position, plus the kind's delay, wrapped
    function automatic int exp_rise(int mode, int vt, int ht, int start);
        for (int k = 0; k < 4 * LINE; k++) begin
            int p = (start + k) % FRAME;
            int v = p / LINE;
            int h = p % LINE;
            bit hit = (mode == 1) ? (v == vt) :
                      (mode == 2) ? (h == ht) : (v == vt && h == ht);
            if (hit) return (p + ((mode == 1) ? 10 : 14)) % FRAME;
        end
        return -1;
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr(int sel, int data);
        cfg_we    = 1'b1;
        cfg_sel   = 2'(sel);
        cfg_wdata = 16'(data);
        step();
        cfg_we = 1'b0;
    endtask

    task automatic jump(int v, int h);
        jmp = 1'b1;
        jv  = 9'(v);
        jh  = 11'(h);
        step();
        jmp = 1'b0;
    endtask

    task automatic pulse_irq_ack();
        irq_ack = 1'b1;
        step();
        irq_ack = 1'b0;
    endtask

    task automatic wait_rise(bit use_nmi, int maxc, output int pos);
        pos = -1;
        for (int i = 0; i < maxc && pos < 0; i++) begin
            step();
            if (use_nmi ? nmi_req : irq) pos = idx(int'(bv), int'(bh));
        end
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        summary();
        $finish;
    end

    initial begin
        int p, e, seen;
        void'($urandom(32'd4711));
        step(); step();
        // R1 during reset
        check(!irq && !nmi_req, "R1", "outputs in reset", {irq, nmi_req}, 0);
        rst = 1'b0;
        step();
        check(!irq && !nmi_req, "R1", "outputs after reset", {irq, nmi_req}, 0);

        // R2: vertical only, delay 10
        wr(2, 30);
        wr(0, 3'b010);
        jump(29, 1300);
        wait_rise(1'b0, 3000, p);
        check(p == idx(30, 10), "R2", "vertical irq position", p, idx(30, 10));
        // R6: stays set while the line continues and after it ends
        repeat (40) step();
        check(irq, "R6", "irq held in line", irq, 1);
        jump(31, 0);
        repeat (5) step();
        check(irq, "R6", "irq held after condition gone", irq, 1);
        pulse_irq_ack();
        check(!irq, "R6", "irq cleared by ack", irq, 0);

        // R3: horizontal only, delay 14
        wr(0, 0);
        wr(1, 500);
        jump(40, 0);
        wr(0, 3'b100);
        wait_rise(1'b0, 3000, p);
        check(p == idx(40, 514), "R3", "horizontal irq position", p, idx(40, 514));

        // R3 + R5: both compares, delay crosses into next line
        wr(0, 0);
        check(!irq, "R9", "disable write clears irq", irq, 0);
        wr(2, 50);
        wr(1, 1360);
        wr(0, 3'b110);
        jump(50, 1300);
        wait_rise(1'b0, 3000, p);
        check(p == idx(51, 10), "R5", "combined irq wraps line", p, idx(51, 10));

        // R7 + R5 + R2: enable written in the cycle before the late trigger
        wr(0, 0);
        wr(2, 215);
        jump(215, 1357);
        step();
        step();
        wr(0, 3'b010);
        check(!irq, "R7", "no irq from write cycle", irq, 0);
        wait_rise(1'b0, 3000, p);
        check(p == idx(216, 6), "R7", "late vertical enable wraps", p, idx(216, 6));

        // R8: second match inside a running countdown is ignored
        wr(0, 0);
        wr(1, 100);
        jump(60, 95);
        wr(0, 3'b100);
        while (bh != 11'd103) step();
        wr(1, 105);
        wait_rise(1'b0, 3000, p);
        check(p == idx(60, 114), "R8", "first countdown unchanged", p, idx(60, 114));
        pulse_irq_ack();
        seen = 0;
        while (bh < 11'd600) begin
            step();
            if (irq) seen++;
        end
        check(seen == 0, "R8", "no second irq from ignored match", seen, 0);

        // R9: disable clears latch and cancels pending countdown
        wr(1, 700);
        wait_rise(1'b0, 3000, p);
        check(p == idx(60, 714), "R3", "horizontal irq after compare change", p, idx(60, 714));
        wr(0, 0);
        check(!irq, "R9", "disable clears latched irq", irq, 0);
        wr(0, 3'b100);
        jump(70, 695);
        while (bh != 11'd705) step();
        wr(0, 0);
        seen = 0;
        repeat (400) begin
            step();
            if (irq) seen++;
        end
        check(seen == 0, "R9", "pending countdown cancelled", seen, 0);

        // R10: IRQ sources off
        wr(1, 900);
        wr(2, int'(bv));
        seen = 0;
        repeat (3000) begin
            step();
            if (irq) seen++;
        end
        check(seen == 0, "R10", "no irq with sources off", seen, 0);

        // R4: NMI, delay 2, held until its ack
        wr(0, 3'b001);
        jump(224, 1360);
        wait_rise(1'b1, 100, p);
        check(p == idx(225, 2), "R4", "nmi position", p, idx(225, 2));
        repeat (50) step();
        check(nmi_req && !irq, "R4", "nmi held, irq quiet", {nmi_req, irq}, 2);
        nmi_ack = 1'b1;
        step();
        nmi_ack = 1'b0;
        check(!nmi_req, "R4", "nmi cleared by ack", nmi_req, 0);
        wr(0, 0);

        // random trials across modes (R2, R3)
        for (int t = 0; t < 12; t++) begin
            int mode = int'($urandom_range(1, 3));
            int vt   = int'($urandom_range(1, LINES - 1));
            int ht   = int'($urandom_range(0, LINE - 1));
            int sv, sh, env, st;
            if (mode == 1) begin
                sv = vt - int'($urandom_range(0, 1));
                sh = int'($urandom_range(0, 1300));
            end else if (mode == 3) begin
                sv = vt - 1;
                sh = int'($urandom_range(0, LINE - 1));
            end else begin
                sv = int'($urandom_range(0, LINES - 1));
                sh = int'($urandom_range(0, LINE - 1));
            end
            env = (mode == 1) ? 3'b010 : (mode == 2) ? 3'b100 : 3'b110;
            wr(0, 0);
            pulse_irq_ack();
            wr(2, vt);
            wr(1, ht);
            jump(sv, sh);
            wr(0, env);
            st = (idx(sv, sh) + 1) % FRAME;
            e  = exp_rise(mode, vt, ht, st);
            wait_rise(1'b0, 4 * LINE + 20, p);
            check(p == e, (mode == 1) ? "R2" : "R3", "random trial position", p, e);
        end

        summary();
        $finish;
    end

endmodule